// File: doc/BRIEF.md
# Programmable UART Frame Transmitter

This block takes bytes from a transmit queue and sends them out one bit at a time on a single serial line. The frame format is set by static inputs: the number of data bits (five to eight), the parity mode and the number of stop bits. A baud-tick enable from an external divider sets the bit timing. Every bit lasts a fixed number of tick enables, and the line changes only on tick boundaries. The queue is read through a valid/ready pop interface. A word is taken in the same cycle that its frame starts.

A one-cycle break request is stored until the line is free. The current frame always finishes first. The block then drives the line low for exactly one frame time at the current format, and then goes back to draining the queue. When automatic flow control is on, a new frame starts only while the active-low clear-to-send input is asserted. This input is looked at only when a frame may start, so a frame that has started always completes. Frames are sent back to back with no idle gap between them.

Top module: `uart_frame_tx`

## Requirements
- R1: During and right after reset, txd is 1, busy is 0 and q_ready is 0.
- R2: A frame is a start bit (0), then the data bits least-significant first, then optional parity, then stop bits (1). len_sel codes 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits. Queue bits above the selected width are not sent.
- R3: parity_mode code 0 sends no parity bit. Code 1 sends odd parity and code 2 sends even parity, both taken over the sent data bits only. Code 3 sends a constant 1 and code 4 a constant 0. Codes 5 to 7 send no parity bit.
- R4: two_stop=0 sends one stop bit. two_stop=1 sends two.
- R5: Every bit lasts exactly 16 baud_tick enables. txd changes only in the cycle after a clock edge at which baud_tick was 1.
- R6: A break drives txd to 0 for exactly 1 + data bits + parity bit + stop bits bit times at the current format. The line then returns to 1, or the next frame starts.
- R7: A break request that arrives during a frame waits until that frame's last stop bit has ended. A pending break goes before any queued word.
- R8: After the break, words still in the queue are sent in order.
- R9: With afc_en=1, a frame starts only while cts_n is 0. With afc_en=0, cts_n has no effect.
- R10: A frame that has started completes unchanged even if cts_n goes to 1 during it.
- R11: busy is 1 from the start bit until the last stop bit or the end of the break. A queued word that is allowed to go starts right at the end of the previous frame, and busy stays 1 across the join.
- R12: q_ready is 1 for exactly one cycle per word sent, only while q_valid is 1, in the cycle the start bit begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | Oversampling tick enable, 16 per bit |
| len_sel | input | 2 | Data width code, 0..3 for 5..8 bits |
| parity_mode | input | 3 | Parity code (none, odd, even, one, zero) |
| two_stop | input | 1 | 1 selects two stop bits |
| afc_en | input | 1 | Enables clear-to-send gating of frame start |
| cts_n | input | 1 | Active-low clear-to-send |
| break_req | input | 1 | One-cycle request for a break frame |
| q_valid | input | 1 | Transmit queue holds a word |
| q_data | input | 8 | Word at the queue head |
| q_ready | output | 1 | Pops the queue head |
| txd | output | 1 | Serial output, idle high |
| busy | output | 1 | A frame or break is in progress |

## Verification
Single frames are sent in each data width and each parity code, with one and with two stop bits. The data values have upper bits set and mixed bit patterns, so dropped bits, reversed bit order and inverted parity give different line values. Back-to-back words separate a chained start from a start that waits for a gap. A break requested while idle is told apart from one requested during a frame by whether it waits for the last stop bit, and the word queued behind it shows that the break goes first and that draining resumes. Clear-to-send is held off while idle and dropped partway through a frame, to show that gating happens only at frame start. One sparse-tick run pins each bit edge to the sixteenth tick.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_START  = 3'd1,
        ST_DATA   = 3'd2,
        ST_PARITY = 3'd3,
        ST_STOP   = 3'd4,
        ST_BREAK  = 3'd5
    } tx_state_e;

    localparam logic [2:0] PAR_NONE = 3'd0;
    localparam logic [2:0] PAR_ODD  = 3'd1;
    localparam logic [2:0] PAR_EVEN = 3'd2;
    localparam logic [2:0] PAR_ONE  = 3'd3;
    localparam logic [2:0] PAR_ZERO = 3'd4;

endpackage

// File: rtl/uart_tx_ticker.sv
module uart_tx_ticker #(
    parameter int OSR = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic hold,
    output logic bit_end
);
    localparam int CW = (OSR > 1) ? $clog2(OSR) : 1;
    localparam logic [CW-1:0] LAST = CW'(OSR - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (hold) begin
            cnt_d = '0;
        end else if (tick) begin
            cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign bit_end = tick && !hold && (cnt_q == LAST);

endmodule

// File: rtl/uart_tx_parity.sv
module uart_tx_parity
    import uart_tx_pkg::*;
#(
    parameter int DW = 8,
    parameter int SW = 2
) (
    input  logic [DW-1:0] data,
    input  logic [SW-1:0] len_sel,
    input  logic [2:0]    mode,
    output logic          par_en,
    output logic          par_bit
);
    localparam int MINW = DW - (2 ** SW) + 1;

    logic [DW-1:0] mask;
    logic          red;

    always_comb begin
        for (int i = 0; i < DW; i++) begin
            mask[i] = (i < MINW + int'(len_sel));
        end
        red     = ^(data & mask);
        par_en  = 1'b1;
        par_bit = 1'b0;
        case (mode)
            PAR_ODD:  par_bit = ~red;
            PAR_EVEN: par_bit = red;
            PAR_ONE:  par_bit = 1'b1;
            PAR_ZERO: par_bit = 1'b0;
            default:  par_en  = 1'b0;
        endcase
    end

endmodule

// File: rtl/uart_tx_fsm.sv
module uart_tx_fsm
    import uart_tx_pkg::*;
#(
    parameter int DW = 8,
    parameter int SW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          bit_end,
    input  logic [SW-1:0] len_sel,
    input  logic          par_en_in,
    input  logic          par_bit_in,
    input  logic          two_stop,
    input  logic          afc_en,
    input  logic          cts_n,
    input  logic          brk_req,
    input  logic          q_valid,
    input  logic [DW-1:0] q_data,
    output logic          q_ready,
    output logic          txd,
    output logic          busy,
    output logic          cnt_hold
);
    localparam int MINW = DW - (2 ** SW) + 1;
    localparam int IW   = $clog2(DW + 5);

    typedef struct packed {
        tx_state_e     state;
        logic [DW-1:0] shift;
        logic [IW-1:0] idx;
        logic [IW-1:0] last;
        logic          par_en;
        logic          par_bit;
        logic          two_stop;
        logic          brk_pend;
    } fsm_t;

    fsm_t r_d, r_q;
    logic pend;
    logic relaunch;
    logic cts_ok;
    int   nbits;
    int   frame_bits;

    assign cts_ok = !afc_en || !cts_n;

    always_comb begin
        nbits      = MINW + int'(len_sel);
        frame_bits = 1 + nbits + (par_en_in ? 1 : 0) + (two_stop ? 2 : 1);
    end

    always_comb begin
        r_d          = r_q;
        q_ready      = 1'b0;
        relaunch     = 1'b0;
        pend         = r_q.brk_pend | brk_req;
        r_d.brk_pend = pend;

        case (r_q.state)
            ST_IDLE: relaunch = tick;
            ST_START: begin
                if (bit_end) begin
                    r_d.state = ST_DATA;
                    r_d.idx   = '0;
                end
            end
            ST_DATA: begin
                if (bit_end) begin
                    r_d.shift = r_q.shift >> 1;
                    if (r_q.idx == r_q.last) begin
                        r_d.state = r_q.par_en ? ST_PARITY : ST_STOP;
                        r_d.idx   = '0;
                    end else begin
                        r_d.idx = r_q.idx + 1'b1;
                    end
                end
            end
            ST_PARITY: begin
                if (bit_end) begin
                    r_d.state = ST_STOP;
                    r_d.idx   = '0;
                end
            end
            ST_STOP: begin
                if (bit_end) begin
                    if (r_q.two_stop && (r_q.idx == '0)) r_d.idx = r_q.idx + 1'b1;
                    else                                 relaunch = 1'b1;
                end
            end
            ST_BREAK: begin
                if (bit_end) begin
                    if (r_q.idx == r_q.last) relaunch = 1'b1;
                    else                     r_d.idx = r_q.idx + 1'b1;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase

        if (relaunch) begin
            if (pend) begin
                r_d.state    = ST_BREAK;
                r_d.idx      = '0;
                r_d.last     = IW'(frame_bits - 1);
                r_d.brk_pend = 1'b0;
            end else if (q_valid && cts_ok) begin
                q_ready      = 1'b1;
                r_d.state    = ST_START;
                r_d.shift    = q_data;
                r_d.idx      = '0;
                r_d.last     = IW'(nbits - 1);
                r_d.par_en   = par_en_in;
                r_d.par_bit  = par_bit_in;
                r_d.two_stop = two_stop;
            end else begin
                r_d.state = ST_IDLE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        case (r_q.state)
            ST_START:  txd = 1'b0;
            ST_DATA:   txd = r_q.shift[0];
            ST_PARITY: txd = r_q.par_bit;
            ST_BREAK:  txd = 1'b0;
            default:   txd = 1'b1;
        endcase
    end

    assign busy     = (r_q.state != ST_IDLE);
    assign cnt_hold = (r_q.state == ST_IDLE);

    AST_TXD_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(txd) |-> $past(tick))
        else $error("txd moved without a tick"); // R5
    AST_POP_STARTS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        q_ready |=> (busy && !txd))
        else $error("pop not followed by start bit"); // R2
    AST_BREAK_BEFORE_POP: assert property (@(posedge clk) disable iff (!rst_n)
        q_ready |-> !(r_q.brk_pend || brk_req))
        else $error("word popped while break pending"); // R7
    AST_CTS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        q_ready |-> (!afc_en || !cts_n))
        else $error("word popped without clear-to-send"); // R9
    AST_POP_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        q_ready |-> q_valid)
        else $error("pop with empty queue"); // R12
    AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> txd)
        else $error("line not high when idle"); // R11

endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx #(
    parameter int DATA_W    = 8,
    parameter int LEN_SEL_W = 2,
    parameter int OSR       = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 baud_tick,
    input  logic [LEN_SEL_W-1:0] len_sel,
    input  logic [2:0]           parity_mode,
    input  logic                 two_stop,
    input  logic                 afc_en,
    input  logic                 cts_n,
    input  logic                 break_req,
    input  logic                 q_valid,
    input  logic [DATA_W-1:0]    q_data,
    output logic                 q_ready,
    output logic                 txd,
    output logic                 busy
);
    logic bit_end;
    logic cnt_hold;
    logic par_en;
    logic par_bit;

    uart_tx_ticker #(.OSR(OSR)) u_ticker (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (baud_tick),
        .hold    (cnt_hold),
        .bit_end (bit_end)
    );

    uart_tx_parity #(.DW(DATA_W), .SW(LEN_SEL_W)) u_parity (
        .data    (q_data),
        .len_sel (len_sel),
        .mode    (parity_mode),
        .par_en  (par_en),
        .par_bit (par_bit)
    );

    uart_tx_fsm #(.DW(DATA_W), .SW(LEN_SEL_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (baud_tick),
        .bit_end    (bit_end),
        .len_sel    (len_sel),
        .par_en_in  (par_en),
        .par_bit_in (par_bit),
        .two_stop   (two_stop),
        .afc_en     (afc_en),
        .cts_n      (cts_n),
        .brk_req    (break_req),
        .q_valid    (q_valid),
        .q_data     (q_data),
        .q_ready    (q_ready),
        .txd        (txd),
        .busy       (busy),
        .cnt_hold   (cnt_hold)
    );

endmodule

// File: tb/uart_frame_tx_tb.sv
module uart_frame_tx_tb;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       baud_tick;
    logic [1:0] len_sel;
    logic [2:0] parity_mode;
    logic       two_stop;
    logic       afc_en;
    logic       cts_n;
    logic       break_req;
    logic       q_valid;
    logic [7:0] q_data;
    logic       q_ready;
    logic       txd;
    logic       busy;

    int errors = 0;
    int checks = 0;

    logic [7:0] mem [16];
    int wr = 0;
    int rd = 0;
    int pops = 0;
    int bad_pops = 0;
    int tick_gap = 3;
    int tick_ctr = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    assign q_valid = (rd != wr);
    assign q_data  = mem[rd % 16];

    uart_frame_tx u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .baud_tick   (baud_tick),
        .len_sel     (len_sel),
        .parity_mode (parity_mode),
        .two_stop    (two_stop),
        .afc_en      (afc_en),
        .cts_n       (cts_n),
        .break_req   (break_req),
        .q_valid     (q_valid),
        .q_data      (q_data),
        .q_ready     (q_ready),
        .txd         (txd),
        .busy        (busy)
    );

    always @(posedge clk) begin
        if (q_ready) begin
            if (!q_valid) bad_pops <= bad_pops + 1;
            rd   <= rd + 1;
            pops <= pops + 1;
        end
    end

    initial begin
        baud_tick = 1'b0;
        forever begin
            @(negedge clk);
            tick_ctr++;
            if (tick_ctr >= tick_gap) begin
                baud_tick = 1'b1;
                tick_ctr  = 0;
            end else begin
                baud_tick = 1'b0;
            end
        end
    end

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish (got timeout, expected completion)");
        summary();
    end

    task automatic chk(input logic got, input logic exp, input string what);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b", what, got, exp);
        end
    endtask

    task automatic chk_int(input int got, input int exp, input string what);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", what, got, exp);
        end
    endtask

    task automatic push(input logic [7:0] d);
        mem[wr % 16] = d;
        wr++;
    endtask

    task automatic wait_ticks(input int n);
        repeat (n) begin
            do @(posedge clk); while (baud_tick !== 1'b1);
        end
        @(negedge clk);
    endtask

    task automatic wait_launch(input string what);
        int n = 0;
        while (busy !== 1'b1 && n < 5000) begin
            @(negedge clk);
            n++;
        end
        chk(busy, 1'b1, what);
    endtask

    task automatic wait_idle();
        int n = 0;
        while (busy !== 1'b0 && n < 20000) begin
            @(negedge clk);
            n++;
        end
    endtask

    function automatic logic exp_par(input logic [7:0] d, input int n, input logic [2:0] pm);
        logic r = 1'b0;
        for (int i = 0; i < n; i++) r ^= d[i];
        case (pm)
            3'd1:    return ~r;
            3'd2:    return r;
            3'd3:    return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    // Called at the negedge right after the launch edge; returns at the end-of-frame edge.
    task automatic check_frame(input logic [7:0] d, input logic [1:0] ls, input logic [2:0] pm,
                               input logic ts, input string tag);
        int n = 5 + int'(ls);
        wait_ticks(8);
        chk(txd, 1'b0, {tag, " R2 start bit"});
        for (int i = 0; i < n; i++) begin
            wait_ticks(16);
            chk(txd, d[i], $sformatf("%s R2 data bit %0d", tag, i));
        end
        if (pm >= 3'd1 && pm <= 3'd4) begin
            wait_ticks(16);
            chk(txd, exp_par(d, n, pm), {tag, " R3 parity bit"});
        end
        for (int s = 0; s < (ts ? 2 : 1); s++) begin
            wait_ticks(16);
            chk(txd, 1'b1, $sformatf("%s R4 stop bit %0d", tag, s));
        end
        chk(busy, 1'b1, {tag, " R11 busy through last stop"});
        wait_ticks(8);
    endtask

    task automatic check_break(input int total, input string tag);
        for (int b = 0; b < total; b++) begin
            wait_ticks(b == 0 ? 8 : 16);
            chk(txd, 1'b0, $sformatf("%s R6 break bit %0d", tag, b));
        end
        chk(busy, 1'b1, {tag, " R11 busy through break"});
        wait_ticks(8);
    endtask

    task automatic set_fmt(input logic [1:0] ls, input logic [2:0] pm, input logic ts);
        len_sel     = ls;
        parity_mode = pm;
        two_stop    = ts;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (5) @(negedge clk);
        chk(txd, 1'b1, "R1 txd in reset");
        chk(busy, 1'b0, "R1 busy in reset");
        chk(q_ready, 1'b0, "R1 q_ready in reset");
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(txd, 1'b1, "R1 txd after reset");
        chk(busy, 1'b0, "R1 busy after reset");
    endtask

    task automatic one_frame(input logic [7:0] d, input logic [1:0] ls, input logic [2:0] pm,
                             input logic ts, input string tag);
        set_fmt(ls, pm, ts);
        push(d);
        wait_launch({tag, " R2 launch"});
        check_frame(d, ls, pm, ts, tag);
        chk(busy, 1'b0, {tag, " R11 busy clears"});
        chk(txd, 1'b1, {tag, " R11 line idle high"});
    endtask

    task automatic t_formats();
        tick_gap = 3;
        one_frame(8'hA5, 2'd3, 3'd0, 1'b0, "8N1");
        one_frame(8'hF3, 2'd0, 3'd1, 1'b1, "5O2");
        one_frame(8'h2D, 2'd2, 3'd2, 1'b0, "7E1");
        one_frame(8'hC6, 2'd1, 3'd3, 1'b1, "6M2");
        one_frame(8'h81, 2'd3, 3'd4, 1'b0, "8S1");
        one_frame(8'h6C, 2'd3, 3'd1, 1'b0, "8O1");
        one_frame(8'h0B, 2'd1, 3'd6, 1'b0, "6X1");
    endtask

    task automatic t_tick_align();
        tick_gap = 4;
        set_fmt(2'd3, 3'd0, 1'b0);
        push(8'hFF);
        wait_launch("R5 launch");
        wait_ticks(15);
        chk(txd, 1'b0, "R5 start bit after 15 ticks");
        @(negedge clk);
        chk(txd, 1'b0, "R5 no change between ticks");
        wait_ticks(1);
        chk(txd, 1'b1, "R5 data bit at 16th tick");
        wait_idle();
        chk(txd, 1'b1, "R5 idle after frame");
    endtask

    task automatic t_back2back();
        tick_gap = 1;
        set_fmt(2'd3, 3'd2, 1'b0);
        push(8'h3C);
        push(8'hC1);
        wait_launch("R11 b2b launch");
        check_frame(8'h3C, 2'd3, 3'd2, 1'b0, "b2b first");
        chk(busy, 1'b1, "R11 busy across join");
        chk(txd, 1'b0, "R11 next start bit at once");
        check_frame(8'hC1, 2'd3, 3'd2, 1'b0, "b2b second");
        chk(busy, 1'b0, "R11 busy clears after pair");
    endtask

    task automatic t_break_idle();
        tick_gap = 1;
        set_fmt(2'd3, 3'd0, 1'b0);
        break_req = 1'b1;
        @(negedge clk);
        break_req = 1'b0;
        wait_launch("R6 break launch");
        check_break(10, "brk idle");
        chk(txd, 1'b1, "R6 line high after break");
        chk(busy, 1'b0, "R6 busy clears after break");
    endtask

    task automatic t_break_mid();
        tick_gap = 1;
        set_fmt(2'd2, 3'd2, 1'b1);
        push(8'h55);
        push(8'h9E);
        wait_launch("R7 launch first word");
        fork
            begin
                break_req = 1'b1;
                @(negedge clk);
                break_req = 1'b0;
            end
            check_frame(8'h55, 2'd2, 3'd2, 1'b1, "R7 word before break");
        join
        chk(txd, 1'b0, "R7 break follows the word");
        check_break(11, "brk mid");
        check_frame(8'h9E, 2'd2, 3'd2, 1'b1, "R8 word after break");
        chk(busy, 1'b0, "R8 idle after drain");
    endtask

    task automatic t_cts();
        tick_gap = 2;
        set_fmt(2'd3, 3'd0, 1'b0);
        afc_en = 1'b1;
        cts_n  = 1'b1;
        push(8'h5A);
        wait_ticks(40);
        chk(busy, 1'b0, "R9 held off by cts_n");
        chk(txd, 1'b1, "R9 line idle while held");
        cts_n = 1'b0;
        wait_launch("R9 start on cts");
        push(8'hA7);
        fork
            begin
                wait_ticks(20);
                cts_n = 1'b1;
            end
            check_frame(8'h5A, 2'd3, 3'd0, 1'b0, "R10 frame survives cts drop");
        join
        chk(busy, 1'b0, "R9 next word held at boundary");
        wait_ticks(40);
        chk(busy, 1'b0, "R9 still held");
        cts_n = 1'b0;
        wait_launch("R9 resume on cts");
        check_frame(8'hA7, 2'd3, 3'd0, 1'b0, "R9 held word");
        afc_en = 1'b0;
        cts_n  = 1'b1;
        push(8'h13);
        wait_launch("R9 afc off ignores cts");
        check_frame(8'h13, 2'd3, 3'd0, 1'b0, "R9 afc off");
    endtask

    initial begin
        rst_n     = 1'b0;
        afc_en    = 1'b0;
        cts_n     = 1'b1;
        break_req = 1'b0;
        set_fmt(2'd3, 3'd0, 1'b0);
        t_reset();
        t_formats();
        t_tick_align();
        t_back2back();
        t_break_idle();
        t_break_mid();
        t_cts();
        repeat (4) @(negedge clk);
        chk_int(pops, wr, "R12 one pop per word");
        chk_int(bad_pops, 0, "R12 pop only with valid");
        summary();
    end

endmodule